// File: doc/BRIEF.md
# Processor Clock Source Selector with Card-Sense Interrupt

This block produces the clock for a fully static processor from two sources: a fast master clock and a slow standby clock. A two-bit power-mode request picks one of three behaviours. In run mode the processor clock is the master clock divided by three. In sleep mode the clock is frozen low, and the processor keeps its registers because it is static. In deep-sleep mode the clock follows the standby oscillator. Every change of mode goes through a break-before-make handoff, so the processor never sees a shortened high or low phase.

All logic runs on the master clock. The processor clock leaves the block as a registered level, so it cannot glitch. The standby clock and the card-sense line are both resynchronised through two flops before use. A falling edge on the card-sense line, which marks a card being inserted or pulled, produces a single fixed-length low pulse on the active-low non-maskable interrupt output. Firmware uses that pulse to begin an orderly shutdown.

Top module: `cpuclk_pm`

## Requirements
- R1: With mode code 00 (run), `cpuClk` repeats a pattern of one master cycle high followed by two master cycles low, with a period of exactly 3 master cycles.
- R2: With mode code 01 (sleep) or code 11, `cpuClk` is held low for as long as the code stays applied.
- R3: With mode code 10 (deep sleep), once the handoff is complete `cpuClk` equals the level of `slowClk` sampled two master edges earlier (a two-flop synchroniser followed by the output register).
- R4: Across any sequence of mode changes, every high phase of `cpuClk` lasts either exactly 1 master cycle or one full standby half-period, and every low phase lasts at least 2 master cycles.
- R5: On a mode change, the old source is switched off only at a point where its next output is low. Both sources then stay off for two master cycles. The divider restarts from zero when it is switched on, and the standby source is switched on only while its synchronised level is low.
- R6: `modeReq` is registered once. When the code changes from sleep (01 or 11) to run, the first high of `cpuClk` appears after the 7th master edge that follows the change.
- R7: While `rst` is high, `cpuClk` is 0 and `nmiN` is 1. The block leaves reset in run mode with the divider at zero, so the first high appears after the 3rd edge following the release of reset.
- R8: A falling edge on `cardSenseN` drives `nmiN` low from the 3rd master edge after the change, and holds it low for exactly NMI_CYCLES (default 12) master cycles, even while the sense line stays low.
- R9: A rising edge on `cardSenseN`, or a steady level, never pulls `nmiN` low.
- R10: A new falling edge detected while a pulse is in progress restarts the pulse length from its full value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every flop in the block uses it |
| rst | input | 1 | Synchronous reset, active high |
| slowClk | input | 1 | Standby oscillator, asynchronous to `mclk` |
| modeReq | input | 2 | Power-mode code: 00 run, 01 sleep, 10 deep sleep, 11 sleep |
| cardSenseN | input | 1 | Card-sense line; a falling edge requests an NMI |
| cpuClk | output | 1 | Registered processor clock |
| nmiN | output | 1 | Non-maskable interrupt request, active low |

## Verification
Two things can land in the same master cycle: a falling edge of the card-sense line and a mode change that starts a clock handoff. Both are applied at the same inactive clock edge, once toward sleep and once toward deep sleep. The interrupt is then judged by its exact latency and pulse width. The clock is judged afterwards by a steady-state window for the new mode. Throughout the run, a continuous pulse-width monitor checks that the handoff never leaves a runt phase.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

  // Power-mode request codes
  localparam logic [1:0] REQ_RUN   = 2'b00;
  localparam logic [1:0] REQ_SLEEP = 2'b01;
  localparam logic [1:0] REQ_DEEP  = 2'b10;
  localparam logic [1:0] REQ_HALT  = 2'b11;

  // Source-selection state of the control FSM
  typedef enum logic [2:0] {
    PS_DIV  = 3'd0,  // divided master clock drives the output
    PS_SCK  = 3'd1,  // synchronised standby clock drives the output
    PS_OFF  = 3'd2,  // output frozen low
    PS_GAP1 = 3'd3,  // first idle cycle of the handoff
    PS_GAP2 = 3'd4   // second idle cycle, new source chosen here
  } pwrState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic enDiv;
    logic enSck;
    logic clrCnt;
    logic loadNmi;
  } clkStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic divHighNext;
    logic slowLevel;
    logic senseFall;
  } clkStatus_t;

  function automatic pwrState_t reqTarget(input logic [1:0] req);
    case (req)
      REQ_RUN:  return PS_DIV;
      REQ_DEEP: return PS_SCK;
      default:  return PS_OFF;
    endcase
  endfunction

endpackage

// File: rtl/cpuclk_sync.sv
module cpuclk_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RESET_VAL;
        else     chain[0] <= din;
      end
    end else begin : gRest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RESET_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
  import cpuclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeReq,
  input  clkStatus_t stat,
  output clkStrobe_t stb
);

  logic [1:0] modeQ;
  pwrState_t  state, stateNext, target;

  always_ff @(posedge clk) begin
    if (rst) modeQ <= REQ_RUN;
    else     modeQ <= modeReq;
  end

  assign target = reqTarget(modeQ);

  always_comb begin
    stateNext = state;
    case (state)
      PS_DIV:  if (target != PS_DIV && !stat.divHighNext) stateNext = PS_GAP1;
      PS_SCK:  if (target != PS_SCK && !stat.slowLevel)   stateNext = PS_GAP1;
      PS_OFF:  if (target != PS_OFF)                      stateNext = PS_GAP1;
      PS_GAP1: stateNext = PS_GAP2;
      PS_GAP2: begin
        case (target)
          PS_DIV:  stateNext = PS_DIV;
          PS_SCK:  if (!stat.slowLevel) stateNext = PS_SCK;
          default: stateNext = PS_OFF;
        endcase
      end
      default: stateNext = PS_DIV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PS_DIV;
    else     state <= stateNext;
  end

  always_comb begin
    stb.enDiv   = (state == PS_DIV);
    stb.enSck   = (state == PS_SCK);
    stb.clrCnt  = (state == PS_GAP2) && (target == PS_DIV);
    stb.loadNmi = stat.senseFall;
  end

  // R5: a source is switched on only after two cycles with both sources off
  a_r5_idle_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(stb.enDiv) || $rose(stb.enSck)) |->
      (!$past(stb.enDiv) && !$past(stb.enSck) &&
       !$past(stb.enDiv, 2) && !$past(stb.enSck, 2)))
    else $error("a_r5_idle_gap");

  // R5: sources are never on together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    $past(stb.enDiv) |-> !stb.enSck)
    else $error("a_r5_exclusive");

endmodule

// File: rtl/cpuclk_dp.sv
module cpuclk_dp
  import cpuclk_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int NMI_CYCLES  = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slowClk,
  input  logic       cardSenseN,
  input  clkStrobe_t stb,
  output clkStatus_t stat,
  output logic       cpuClk,
  output logic       nmiN
);

  localparam int              CNT_W    = $clog2(DIV_RATIO);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV_RATIO - 1);
  localparam int              NMI_W    = $clog2(NMI_CYCLES + 1);
  localparam logic [NMI_W-1:0] NMI_LOAD = NMI_W'(NMI_CYCLES - 1);

  logic [CNT_W-1:0] divCnt;
  logic             slowSync, senseSync, sensePrev;
  logic             cpuClkQ, nmiNQ;
  logic [NMI_W-1:0] nmiCnt;

  // Divider
  always_ff @(posedge clk) begin
    if (rst || stb.clrCnt)    divCnt <= '0;
    else if (divCnt == CNT_TOP) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  // Synchronisers
  cpuclk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) slowSyncU (
    .clk(clk), .rst(rst), .din(slowClk), .dout(slowSync));

  cpuclk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) senseSyncU (
    .clk(clk), .rst(rst), .din(cardSenseN), .dout(senseSync));

  always_ff @(posedge clk) begin
    if (rst) sensePrev <= 1'b1;
    else     sensePrev <= senseSync;
  end

  // Output clock register: the only driver of cpuClk
  always_ff @(posedge clk) begin
    if (rst) cpuClkQ <= 1'b0;
    else     cpuClkQ <= (stb.enDiv && divCnt == CNT_TOP) || (stb.enSck && slowSync);
  end

  // NMI pulse stretcher
  always_ff @(posedge clk) begin
    if (rst) begin
      nmiCnt <= '0;
      nmiNQ  <= 1'b1;
    end else if (stb.loadNmi) begin
      nmiCnt <= NMI_LOAD;
      nmiNQ  <= 1'b0;
    end else if (nmiCnt != '0) begin
      nmiCnt <= nmiCnt - 1'b1;
      nmiNQ  <= 1'b0;
    end else begin
      nmiNQ  <= 1'b1;
    end
  end

  always_comb begin
    stat.divHighNext = (divCnt == CNT_TOP);
    stat.slowLevel   = slowSync;
    stat.senseFall   = sensePrev && !senseSync;
  end

  assign cpuClk = cpuClkQ;
  assign nmiN   = nmiNQ;

  // R1: a divided high phase lasts a single master cycle
  a_r1_single_high: assert property (@(posedge clk) disable iff (rst)
    (cpuClkQ && stb.enDiv) |=> !cpuClkQ)
    else $error("a_r1_single_high");

  // R2: with both sources off a low output stays low
  a_r2_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!stb.enDiv && !stb.enSck && !cpuClkQ) |=> !cpuClkQ)
    else $error("a_r2_hold_low");

  // R5: standby source enabled only at a low level
  a_r5_slow_start: assert property (@(posedge clk) disable iff (rst)
    $rose(stb.enSck) |-> (!cpuClkQ && !$past(slowSync)))
    else $error("a_r5_slow_start");

  // R5: divider restarts from zero with the output low
  a_r5_div_start: assert property (@(posedge clk) disable iff (rst)
    $rose(stb.enDiv) |-> (divCnt == '0 && !cpuClkQ))
    else $error("a_r5_div_start");

  // R8: the interrupt falls only after a detected sense edge
  a_r8_nmi_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(nmiNQ) |-> $past(stb.loadNmi))
    else $error("a_r8_nmi_cause");

endmodule

// File: rtl/cpuclk_pm.sv
module cpuclk_pm
  import cpuclk_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int NMI_CYCLES  = 12
) (
  input  logic       mclk,
  input  logic       rst,
  input  logic       slowClk,
  input  logic [1:0] modeReq,
  input  logic       cardSenseN,
  output logic       cpuClk,
  output logic       nmiN
);

  clkStrobe_t stb;
  clkStatus_t stat;

  cpuclk_ctrl ctrlU (
    .clk(mclk), .rst(rst), .modeReq(modeReq), .stat(stat), .stb(stb));

  cpuclk_dp #(
    .DIV_RATIO(DIV_RATIO), .SYNC_STAGES(SYNC_STAGES), .NMI_CYCLES(NMI_CYCLES)
  ) dpU (
    .clk(mclk), .rst(rst), .slowClk(slowClk), .cardSenseN(cardSenseN),
    .stb(stb), .stat(stat), .cpuClk(cpuClk), .nmiN(nmiN));

endmodule

// File: tb/cpuclk_pm_test.sv
module cpuclk_pm_test;

  localparam int SLOW_HALF = 8;
  localparam int NMI_LEN   = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slowClk = 1'b0;
  logic [1:0] modeReq = 2'b00;
  logic       cardSenseN = 1'b1;
  logic       cpuClk, nmiN;

  int checks = 0;
  int errors = 0;
  logic monOn = 1'b0;

  cpuclk_pm uut (
    .mclk(clk), .rst(rst), .slowClk(slowClk), .modeReq(modeReq),
    .cardSenseN(cardSenseN), .cpuClk(cpuClk), .nmiN(nmiN));

  always #4 clk = ~clk;

  initial forever begin
    repeat (SLOW_HALF) @(negedge clk);
    slowClk = ~slowClk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Continuous pulse-width monitor (R4)
  initial begin
    bit primed = 0;
    bit skipFirst = 1;
    logic lastLvl = 1'b0;
    int runLen = 0;
    forever begin
      @(posedge clk); #1;
      if (!monOn) begin
        primed = 0;
      end else if (!primed) begin
        primed = 1; skipFirst = 1; lastLvl = cpuClk; runLen = 1;
      end else if (cpuClk == lastLvl) begin
        runLen++;
      end else begin
        if (!skipFirst) begin
          if (lastLvl) check(runLen == 1 || runLen == SLOW_HALF, "R4 high phase", runLen, 1);
          else         check(runLen >= 2, "R4 low phase", runLen, 2);
        end
        skipFirst = 0; lastLvl = cpuClk; runLen = 1;
      end
    end
  end

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); modeReq = m;
  endtask

  task automatic windowCheck(input logic [1:0] m);
    logic cpuH[48];
    logic slowH[48];
    int highs = 0;
    int lastHigh = -1;
    bit gapsOk = 1;
    int mism = 0;
    for (int i = 0; i < 48; i++) begin
      @(posedge clk); #1;
      cpuH[i] = cpuClk; slowH[i] = slowClk;
      if (cpuClk) begin
        highs++;
        if (lastHigh >= 0 && i - lastHigh != 3) gapsOk = 0;
        lastHigh = i;
      end
      if (i >= 2 && cpuH[i] != slowH[i-2]) mism++;
    end
    case (m)
      2'b00:   check(highs == 16 && gapsOk, "R1 run window highs", highs, 16);
      2'b10:   check(mism == 0, "R3 deep-sleep lag mismatches", mism, 0);
      default: check(highs == 0, "R2 sleep window highs", highs, 0);
    endcase
  endtask

  task automatic firstHighAfter(input int expN, input string req);
    int found = -1;
    for (int n = 1; n <= 20; n++) begin
      @(posedge clk); #1;
      if (cpuClk && found < 0) found = n;
    end
    check(found == expN, req, found, expN);
  endtask

  task automatic nmiRun(input int hiAt, input int loAt, input int modeAt,
                        input logic [1:0] modeVal, input int expLen, input string req);
    int first = -1;
    int lows = 0;
    @(negedge clk);
    cardSenseN = 1'b0;
    if (modeAt == 0) modeReq = modeVal;
    for (int n = 1; n <= 40; n++) begin
      @(posedge clk); #1;
      if (!nmiN) begin
        lows++;
        if (first < 0) first = n;
      end
      @(negedge clk);
      if (n == hiAt) cardSenseN = 1'b1;
      if (n == loAt) cardSenseN = 1'b0;
    end
    cardSenseN = 1'b1;
    check(first == 3, {req, " latency"}, first, 3);
    check(lows == expLen, {req, " width"}, lows, expLen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lows;
    repeat (5) @(negedge clk);
    check(cpuClk == 1'b0, "R7 cpuClk in reset", cpuClk, 0);
    check(nmiN == 1'b1, "R7 nmiN in reset", nmiN, 1);
    rst = 1'b0;
    firstHighAfter(3, "R7 first high after reset");
    monOn = 1'b1;
    windowCheck(2'b00);

    // Near-exhaustive sweep of ordered mode pairs at three phases (R1 R2 R3 R4 R5)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int ph = 0; ph < 3; ph++) begin
          setMode(2'(a));
          repeat (40 + ph) @(posedge clk);
          setMode(2'(b));
          repeat (40) @(posedge clk);
          windowCheck(2'(b));
        end

    // R6: wake latency from both sleep codes
    setMode(2'b01); repeat (30) @(posedge clk);
    setMode(2'b00); firstHighAfter(7, "R6 wake from 01");
    setMode(2'b11); repeat (30) @(posedge clk);
    setMode(2'b00); firstHighAfter(7, "R6 wake from 11");
    repeat (20) @(posedge clk);

    // R8: single pulse while the line stays low
    nmiRun(0, 0, -1, 2'b00, NMI_LEN, "R8 single");
    // R9: rising edge just applied, then steady high
    lows = 0;
    for (int n = 0; n < 30; n++) begin
      @(posedge clk); #1;
      if (!nmiN) lows++;
    end
    check(lows == 0, "R9 rise gives no pulse", lows, 0);
    // R10: retrigger during a pulse
    nmiRun(2, 4, -1, 2'b00, NMI_LEN + 4, "R10 retrigger");
    repeat (20) @(posedge clk);

    // Sense edge and mode change in the same cycle (R8 with R2, R3)
    nmiRun(0, 0, 0, 2'b01, NMI_LEN, "R8 with sleep entry");
    windowCheck(2'b01);
    setMode(2'b00); repeat (30) @(posedge clk);
    nmiRun(0, 0, 0, 2'b10, NMI_LEN, "R8 with deep-sleep entry");
    repeat (20) @(posedge clk);
    windowCheck(2'b10);

    monOn = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule